// File: doc/BRIEF.md
# Four-Slot Descriptor DMA Engine

This block copies dwords between a small local data RAM and a distant framebuffer, and it runs on its own while the core goes on executing. Software programs it over a narrow local bus that has 8-bit register indices and 32-bit data. The register file holds four descriptor slots. Each slot is a pair of registers: a packed command word and a framebuffer start address. A single launch register follows the slots. Writing the number of slots to run into the launch register starts them in order from slot 0. Reading the launch register shows whether the engine is still working.

The engine has two master ports, one to the local RAM and one to the framebuffer. Each port is a plain dword request/acknowledge interface. For every dword the engine reads the source memory and then writes the destination memory, and only one port has a request up at any time. Both memories are addressed in dwords. Nothing arbitrates against the core's own RAM traffic, so overlapping accesses collide without any warning.

Top module: `dma4_sg`

## Requirements
- R1: Register index 2k holds the command word of slot k and index 2k+1 holds its framebuffer start address, for k from 0 to 3. Each reads back the value last written. All eight are zero after reset.
- R2: Command word fields: bits 15:0 are the local RAM dword address, bits 27:16 are the dword count, and bits 30:28 have no effect. Bit 31 set means the data moves from the framebuffer into the local RAM.
- R3: Bit 31 clear means the data moves from the local RAM out to the framebuffer.
- R4: Within a slot, the RAM address and the framebuffer address each rise by one for every dword moved, and exactly count dwords are moved.
- R5: Writing n, with n from 1 to 4, to index 8 while idle runs slots 0 to n-1 strictly in order. Each slot finishes before the next one begins.
- R6: Reading index 8 returns a non-zero value while busy and zero when idle. Busy clears one cycle after the last write acknowledge of the final slot.
- R7: A slot with a count of zero makes no memory access and passes straight on to the next slot.
- R8: While busy, writes to indices 0 to 7 and to index 8 are ignored.
- R9: Writing 0 or any value above 4 to index 8 is ignored, and the engine stays idle.
- R10: At most one of ram_req and fb_req is high at any time. A request stays high, with its address, write enable and write data unchanged, until it is acknowledged.
- R11: After reset the engine is idle and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational) |
| ram_req | output | 1 | Local RAM request |
| ram_we | output | 1 | Local RAM write (1) / read (0) |
| ram_addr | output | 16 | Local RAM dword address |
| ram_wdata | output | 32 | Local RAM write data |
| ram_rdata | input | 32 | Local RAM read data, valid with ram_ack |
| ram_ack | input | 1 | Local RAM acknowledge |
| fb_req | output | 1 | Framebuffer request |
| fb_we | output | 1 | Framebuffer write (1) / read (0) |
| fb_addr | output | 32 | Framebuffer dword address |
| fb_wdata | output | 32 | Framebuffer write data |
| fb_rdata | input | 32 | Framebuffer read data, valid with fb_ack |
| fb_ack | input | 1 | Framebuffer acknowledge |

## Verification
The assertions check several rules on every cycle. Only one master port may request at a time, and a pending request must hold steady until its acknowledge. An idle engine must keep both ports quiet. The slot registers must stay frozen while busy. A valid launch must raise busy, and an invalid one must leave the engine idle. Other behaviour shows up only in the bench scenarios, because it depends on contents left in memory: the field decoding, the address stepping, the slot order (seen through chained slots whose regions overlap), the skipping of zero-count slots, and the exact cycle in which busy clears.

// File: rtl/dma4_sg.sv
module dma4_sg #(
  parameter int NSLOT = 4,
  parameter int CNT_W = 12,
  parameter int LA_W  = 16,
  parameter int FB_AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             ram_req,
  output logic             ram_we,
  output logic [LA_W-1:0]  ram_addr,
  output logic [31:0]      ram_wdata,
  input  logic [31:0]      ram_rdata,
  input  logic             ram_ack,
  output logic             fb_req,
  output logic             fb_we,
  output logic [FB_AW-1:0] fb_addr,
  output logic [31:0]      fb_wdata,
  input  logic [31:0]      fb_rdata,
  input  logic             fb_ack
);
  localparam int SW   = $clog2(NSLOT);
  localparam int TRIG = 2 * NSLOT;

  typedef enum logic [1:0] {S_IDLE, S_SLOT, S_RD, S_WR} st_t;

  st_t              st;
  logic [31:0]      cmd_q [NSLOT];
  logic [31:0]      fba_q [NSLOT];
  logic [SW-1:0]    slot, last_slot;
  logic [CNT_W-1:0] remain;
  logic [LA_W-1:0]  lptr;
  logic [FB_AW-1:0] fptr;
  logic [31:0]      dbuf;
  logic             dir_in;

  wire busy    = (st != S_IDLE);
  wire cfg_hit = bus_addr < 8'(TRIG);
  wire cfg_wr  = bus_we && cfg_hit && !busy;
  wire trig_ok = bus_wdata != 32'd0 && bus_wdata <= 32'(NSLOT);
  wire launch  = bus_we && bus_addr == 8'(TRIG) && !busy && trig_ok;
  wire [SW-1:0] cidx = bus_addr[SW:1];

  wire [CNT_W-1:0] cur_cnt = cmd_q[slot][16 +: CNT_W];
  wire src_ack = dir_in ? fb_ack : ram_ack;
  wire dst_ack = dir_in ? ram_ack : fb_ack;
  wire [31:0] src_data = dir_in ? fb_rdata : ram_rdata;

  assign ram_req   = (st == S_RD && !dir_in) || (st == S_WR && dir_in);
  assign fb_req    = (st == S_RD && dir_in) || (st == S_WR && !dir_in);
  assign ram_we    = (st == S_WR);
  assign fb_we     = (st == S_WR);
  assign ram_addr  = lptr;
  assign fb_addr   = fptr;
  assign ram_wdata = dbuf;
  assign fb_wdata  = dbuf;

  always_comb begin
    bus_rdata = 32'd0;
    if (cfg_hit) bus_rdata = bus_addr[0] ? fba_q[cidx] : cmd_q[cidx];
    else if (bus_addr == 8'(TRIG)) bus_rdata = {31'd0, busy};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        cmd_q[i] <= '0;
        fba_q[i] <= '0;
      end
    end else if (cfg_wr) begin
      if (bus_addr[0]) fba_q[cidx] <= bus_wdata;
      else             cmd_q[cidx] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      slot      <= '0;
      last_slot <= '0;
      remain    <= '0;
      lptr      <= '0;
      fptr      <= '0;
      dbuf      <= '0;
      dir_in    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (launch) begin
          slot      <= '0;
          last_slot <= SW'(bus_wdata - 32'd1);
          st        <= S_SLOT;
        end
        S_SLOT: begin
          if (cur_cnt == '0) begin
            if (slot == last_slot) st <= S_IDLE;
            else slot <= slot + 1'b1;
          end else begin
            lptr   <= cmd_q[slot][LA_W-1:0];
            fptr   <= FB_AW'(fba_q[slot]);
            remain <= cur_cnt;
            dir_in <= cmd_q[slot][31];
            st     <= S_RD;
          end
        end
        S_RD: if (src_ack) begin
          dbuf <= src_data;
          st   <= S_WR;
        end
        S_WR: if (dst_ack) begin
          lptr   <= lptr + 1'b1;
          fptr   <= fptr + 1'b1;
          remain <= remain - 1'b1;
          if (remain == CNT_W'(1)) begin
            if (slot == last_slot) st <= S_IDLE;
            else begin
              slot <= slot + 1'b1;
              st   <= S_SLOT;
            end
          end else st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r10_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_req, fb_req}));
  a_r10_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ram_req && !ram_ack |=> ram_req && $stable(ram_addr) && $stable(ram_we) && $stable(ram_wdata));
  a_r10_fb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fb_req && !fb_ack |=> fb_req && $stable(fb_addr) && $stable(fb_we) && $stable(fb_wdata));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ram_req && !fb_req);
  a_r5_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> bus_addr != 8'(TRIG) || bus_rdata != 32'd0);
  a_r9_bad_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && bus_we && bus_addr == 8'(TRIG) && !trig_ok |=> !busy);

  for (genvar g = 0; g < NSLOT; g++) begin : g_frz
    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cmd_q[g]) && $stable(fba_q[g]));
  end
endmodule

// File: tb/sim_dma4_sg.sv
module sim_dma4_sg;
  logic clk = 0, rst_n = 0;
  logic bus_we = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic ram_req, ram_we, ram_ack = 0, fb_req, fb_we, fb_ack = 0;
  logic [15:0] ram_addr;
  logic [31:0] fb_addr, ram_wdata, fb_wdata, ram_rdata = 0, fb_rdata = 0;

  always #4 clk = ~clk;

  dma4_sg u0 (.*);

  logic [31:0] ram_m [256], fb_m [256], exp_ram [256], exp_fb [256];
  logic [31:0] sh_cmd [4], sh_fba [4];
  int total = 0, bad = 0, cyc = 0, nacc = 0, wack_cyc = 0, overlap = 0;
  int ram_wait = 0, fb_wait = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc = cyc + 1;
    ram_ack <= 0;
    fb_ack  <= 0;
    if (ram_req && !ram_ack) begin
      if (ram_wait == 0) begin
        ram_ack <= 1;
        nacc = nacc + 1;
        if (ram_we) begin ram_m[ram_addr[7:0]] = ram_wdata; wack_cyc = cyc; end
        else ram_rdata <= ram_m[ram_addr[7:0]];
        ram_wait = $urandom % 3;
      end else ram_wait = ram_wait - 1;
    end
    if (fb_req && !fb_ack) begin
      if (fb_wait == 0) begin
        fb_ack <= 1;
        nacc = nacc + 1;
        if (fb_we) begin fb_m[fb_addr[7:0]] = fb_wdata; wack_cyc = cyc; end
        else fb_rdata <= fb_m[fb_addr[7:0]];
        fb_wait = $urandom % 3;
      end else fb_wait = fb_wait - 1;
    end
  end

  // R10: monitor for simultaneous requests
  always @(negedge clk) if (rst_n && ram_req && fb_req) overlap = overlap + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_slot(input int k, input bit din, input int cnt, input int la, input int fa);
    logic [31:0] c;
    c = {din, 3'($urandom), 12'(cnt), 16'(la)};
    sh_cmd[k] = c;
    sh_fba[k] = 32'(fa);
    wr(8'(2 * k), c);
    wr(8'(2 * k + 1), 32'(fa));
  endtask

  function automatic int model(input int n);
    int acc = 0;
    for (int s = 0; s < n; s++) begin
      int cnt = int'(sh_cmd[s][27:16]);
      int la = int'(sh_cmd[s][15:0]);
      int fa = int'(sh_fba[s]);
      for (int i = 0; i < cnt; i++) begin
        if (sh_cmd[s][31]) exp_ram[(la + i) % 256] = exp_fb[(fa + i) % 256];
        else exp_fb[(fa + i) % 256] = exp_ram[(la + i) % 256];
      end
      acc += 2 * cnt;
    end
    return acc;
  endfunction

  task automatic cmp_mem(input string req);
    int e = 0;
    logic [31:0] a = 0, x = 0;
    for (int i = 0; i < 256; i++) begin
      if (ram_m[i] !== exp_ram[i] && e == 0) begin e = 1; a = ram_m[i]; x = exp_ram[i]; end
      if (fb_m[i] !== exp_fb[i] && e == 0) begin e = 1; a = fb_m[i]; x = exp_fb[i]; end
    end
    check({req, " memory"}, a, x);
  endtask

  task automatic run(input int n, input string req, input bit tamper);
    int a0, exp_acc, t0;
    logic [31:0] st;
    a0 = nacc;
    exp_acc = model(n);
    wr(8'd8, 32'(n));
    t0 = cyc;
    if (tamper) begin
      wr(8'd0, 32'hDEAD_BEEF);
      wr(8'd8, 32'd4);
    end
    st = 1;
    while (st != 0 && cyc - t0 < 20000) rd(8'd8, st);
    if (sh_cmd[n-1][27:16] != 0)
      check("R6 busy clears one cycle after last write ack", 32'(cyc), 32'(wack_cyc + 1));
    check({req, " access count"}, 32'(nacc - a0), 32'(exp_acc));
    cmp_mem(req);
  endtask

  initial begin
    #(8 * 190000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int a0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      ram_m[i] = $urandom; fb_m[i] = $urandom;
      exp_ram[i] = ram_m[i]; exp_fb[i] = fb_m[i];
    end
    repeat (3) @(negedge clk);
    check("R11 ram_req after reset", 32'(ram_req), 0);
    check("R11 fb_req after reset", 32'(fb_req), 0);
    rst_n = 1;
    rd(8'd8, v); check("R11 status idle after reset", v, 0);
    rd(8'd5, v); check("R1 register zero after reset", v, 0);

    // R1 readback
    for (int k = 0; k < 4; k++) set_slot(k, 1'b1, 1, 10 * k, 20 * k);
    for (int k = 0; k < 4; k++) begin
      rd(8'(2 * k), v); check("R1 cmd readback", v, sh_cmd[k]);
      rd(8'(2 * k + 1), v); check("R1 fb readback", v, sh_fba[k]);
    end

    // R2 inbound single dword, R3 outbound multi dword, R4 stepping
    set_slot(0, 1'b1, 1, 3, 77);
    run(1, "R2 inbound", 0);
    set_slot(0, 1'b0, 9, 40, 130);
    run(1, "R3 R4 outbound", 0);
    set_slot(0, 1'b1, 12, 100, 200);
    run(1, "R4 inbound stepping", 0);

    // R5 order: chained overlapping slots
    set_slot(0, 1'b1, 5, 60, 10);
    set_slot(1, 1'b0, 5, 60, 150);
    set_slot(2, 1'b1, 5, 62, 150);
    set_slot(3, 1'b0, 6, 61, 30);
    run(4, "R5 ordered slots", 0);

    // R7 zero count in middle and at end
    set_slot(0, 1'b0, 3, 5, 5);
    set_slot(1, 1'b1, 0, 90, 90);
    set_slot(2, 1'b1, 4, 20, 50);
    set_slot(3, 1'b0, 0, 0, 0);
    run(4, "R7 zero count slots", 0);

    // R8 writes while busy ignored
    set_slot(0, 1'b0, 30, 150, 180);
    run(1, "R8 busy writes", 1);
    rd(8'd0, v); check("R8 cmd unchanged after busy write", v, sh_cmd[0]);

    // R9 invalid triggers
    a0 = nacc;
    wr(8'd8, 32'd0);
    rd(8'd8, v); check("R9 trigger 0 stays idle", v, 0);
    wr(8'd8, 32'd5);
    rd(8'd8, v); check("R9 trigger 5 stays idle", v, 0);
    repeat (5) @(negedge clk);
    check("R9 no accesses after invalid trigger", 32'(nacc - a0), 0);

    // random lists
    for (int r = 0; r < 30; r++) begin
      int n = 1 + $urandom % 4;
      for (int k = 0; k < 4; k++)
        set_slot(k, 1'($urandom), $urandom % 17, $urandom % 230, $urandom % 230);
      run(n, "R5 random list", 0);
    end

    check("R10 requests never overlap", 32'(overlap), 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule